// File: doc/BRIEF.md
# Signaling NaN quieting unit

This block takes one floating-point operand per cycle and, if it is a signaling NaN, returns a quiet NaN with the invalid-operation flag set. Every other operand passes through unchanged and leaves the flag clear. The operand is either binary32 or binary64, chosen by a format input. A mode input chooses how NaNs are encoded.

In the 2008 encoding, a quiet NaN has the top fraction bit set. Quieting sets that bit. In the legacy encoding the meaning of that bit is inverted: a set top fraction bit marks a signaling NaN. Quieting therefore clears the bit and keeps the sign and payload. If clearing the bit would leave the fraction all zero, the result would encode infinity. In that case the next lower fraction bit is set instead, so the sign is still kept. No default NaN pattern is ever substituted.

The result, the flag and a valid strobe are registered. This gives one cycle of latency. A new operand can be accepted on every cycle.

Top module: `snan_quieter`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock edge. A synchronous `rst` clears `out_valid` and `out_invalid`.
- R2: An operand is classified as a signaling NaN when its exponent is all ones, its fraction is nonzero, and its fraction bit F-1 has a specific value. That bit must be 0 when `in_legacy`=0 (2008 encoding) and 1 when `in_legacy`=1 (legacy encoding). `out_invalid` is 1 exactly for accepted operands that are signaling NaNs.
- R3: With `in_legacy`=0, a signaling NaN is quieted by setting fraction bit F-1. All other bits are left unchanged.
- R4: With `in_legacy`=1, a signaling NaN is quieted by clearing fraction bit F-1. The sign, the exponent and fraction bits F-2..0 are kept.
- R5: With `in_legacy`=1, if clearing bit F-1 leaves an all-zero fraction, fraction bit F-2 is set. The result stays a NaN with the operand's sign.
- R6: Operands that are not signaling NaNs under the selected mode are output unchanged with `out_invalid`=0. This covers quiet NaNs, infinities, zeros and finite numbers.
- R7: `in_dbl`=1 selects binary64: 1 sign bit, 11 exponent bits, F=52, using all 64 bits. `in_dbl`=0 selects binary32: 1 sign bit, 8 exponent bits, F=23, held in bits 31..0. In binary32, bits 63..32 of the operand are ignored and bits 63..32 of the result are 0.
- R8: `out_invalid` is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Operand; binary32 in bits 31..0 |
| in_dbl | input | 1 | 1 = binary64, 0 = binary32 |
| in_legacy | input | 1 | 1 = legacy NaN encoding, 0 = 2008 encoding |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_res | output | 64 | Quieted or passed-through operand |
| out_invalid | output | 1 | Invalid-operation flag for a quieted signaling NaN |

## Verification
The bench targets the legacy infinity corner, in both formats and with both signs. A design that only cleared the quiet bit would return an infinity there. A design that substituted a default NaN would lose the sign.

Quiet NaNs and infinities are presented under both modes. A design that inverted the quiet-bit test, or that ignored the zero-fraction check, would raise the flag wrongly or rewrite those operands.

Binary32 operands carry junk in the upper half. A binary64 pattern is also chosen so that only its low word looks like a signaling NaN. Both catch a design that mixes up the format select or leaks the upper bits.

A strobe held low while a signaling NaN sits on the input, and a reset applied during traffic, show whether the flag is properly gated.

// File: rtl/snan_quieter.sv
module snan_quieter #(
  parameter int EXP_D  = 11,
  parameter int FRAC_D = 52,
  parameter int EXP_S  = 8,
  parameter int FRAC_S = 23
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [EXP_D+FRAC_D:0]       in_op,
  input  logic                        in_dbl,
  input  logic                        in_legacy,
  output logic                        out_valid,
  output logic [EXP_D+FRAC_D:0]       out_res,
  output logic                        out_invalid
);
  localparam int WD = 1 + EXP_D + FRAC_D;
  localparam int WS = 1 + EXP_S + FRAC_S;

  // binary32 view
  logic [WS-1:0]     s_op;
  logic [EXP_S-1:0]  s_exp;
  logic [FRAC_S-1:0] s_frac, s_frac_leg, s_frac_new;
  logic              s_snan;

  assign s_op   = in_op[WS-1:0];
  assign s_exp  = s_op[FRAC_S +: EXP_S];
  assign s_frac = s_op[FRAC_S-1:0];
  assign s_snan = (&s_exp) && (|s_frac) && (s_frac[FRAC_S-1] == in_legacy);
  assign s_frac_leg = (|s_frac[FRAC_S-2:0]) ? {1'b0, s_frac[FRAC_S-2:0]}
                                            : {2'b01, {(FRAC_S-2){1'b0}}};
  assign s_frac_new = in_legacy ? s_frac_leg : {1'b1, s_frac[FRAC_S-2:0]};

  // binary64 view
  logic [EXP_D-1:0]  d_exp;
  logic [FRAC_D-1:0] d_frac, d_frac_leg, d_frac_new;
  logic              d_snan;

  assign d_exp  = in_op[FRAC_D +: EXP_D];
  assign d_frac = in_op[FRAC_D-1:0];
  assign d_snan = (&d_exp) && (|d_frac) && (d_frac[FRAC_D-1] == in_legacy);
  assign d_frac_leg = (|d_frac[FRAC_D-2:0]) ? {1'b0, d_frac[FRAC_D-2:0]}
                                            : {2'b01, {(FRAC_D-2){1'b0}}};
  assign d_frac_new = in_legacy ? d_frac_leg : {1'b1, d_frac[FRAC_D-2:0]};

  logic          snan;
  logic [WD-1:0] res_d, res_s, res_next;

  assign res_d    = d_snan ? {in_op[WD-1:FRAC_D], d_frac_new} : in_op;
  assign res_s    = {{(WD-WS){1'b0}}, (s_snan ? {s_op[WS-1:FRAC_S], s_frac_new} : s_op)};
  assign res_next = in_dbl ? res_d : res_s;
  assign snan     = in_dbl ? d_snan : s_snan;

  logic fmt_q, mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_res     <= '0;
      fmt_q       <= 1'b0;
      mode_q      <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid && snan;
      if (in_valid) begin
        out_res <= res_next;
        fmt_q   <= in_dbl;
        mode_q  <= in_legacy;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_flag_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_invalid);
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !fmt_q) |-> (out_res[WD-1:WS] == '0));
  p_quiet_2008_r3: assert property (@(posedge clk) disable iff (rst)
    (out_invalid && !mode_q && fmt_q) |->
      ((&out_res[FRAC_D +: EXP_D]) && out_res[FRAC_D-1]));
  p_quiet_legacy_r5: assert property (@(posedge clk) disable iff (rst)
    (out_invalid && mode_q && fmt_q) |->
      ((&out_res[FRAC_D +: EXP_D]) && !out_res[FRAC_D-1] && (|out_res[FRAC_D-2:0])));
  p_quiet_legacy_s_r4: assert property (@(posedge clk) disable iff (rst)
    (out_invalid && mode_q && !fmt_q) |->
      ((&out_res[FRAC_S +: EXP_S]) && !out_res[FRAC_S-1] && (|out_res[FRAC_S-2:0])));
  p_pass_dbl_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_invalid && fmt_q) |-> (out_res == $past(in_op)));
endmodule

// File: tb/snan_quieter_test.sv
module snan_quieter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [15:0] tag;
    logic        dbl;
    logic        leg;
    logic [63:0] op;
    logic [63:0] res;
    logic        flag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{"R3", 1'b1, 1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b1},
    '{"R6", 1'b1, 1'b0, 64'h7FF8_0000_0000_0005, 64'h7FF8_0000_0000_0005, 1'b0},
    '{"R6", 1'b1, 1'b0, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b0},
    '{"R3", 1'b1, 1'b0, 64'hFFF4_0000_0000_0000, 64'hFFFC_0000_0000_0000, 1'b1},
    '{"R4", 1'b1, 1'b1, 64'h7FF8_0000_0000_0001, 64'h7FF0_0000_0000_0001, 1'b1},
    '{"R5", 1'b1, 1'b1, 64'hFFF8_0000_0000_0000, 64'hFFF4_0000_0000_0000, 1'b1},
    '{"R2", 1'b1, 1'b1, 64'h7FF4_0000_0000_0000, 64'h7FF4_0000_0000_0000, 1'b0},
    '{"R6", 1'b1, 1'b1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0},
    '{"R6", 1'b1, 1'b1, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b0},
    '{"R4", 1'b1, 1'b1, 64'h7FFC_0000_0000_0000, 64'h7FF4_0000_0000_0000, 1'b1},
    '{"R7", 1'b0, 1'b0, 64'hDEAD_BEEF_7F80_0001, 64'h0000_0000_7FC0_0001, 1'b1},
    '{"R7", 1'b0, 1'b0, 64'h1234_5678_FFC0_0000, 64'h0000_0000_FFC0_0000, 1'b0},
    '{"R5", 1'b0, 1'b1, 64'h0000_0000_7FC0_0000, 64'h0000_0000_7FA0_0000, 1'b1},
    '{"R4", 1'b0, 1'b1, 64'hFFFF_0000_FFC1_2345, 64'h0000_0000_FF81_2345, 1'b1},
    '{"R2", 1'b0, 1'b1, 64'h0000_0000_7FBF_FFFF, 64'h0000_0000_7FBF_FFFF, 1'b0},
    '{"R6", 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
    '{"R7", 1'b1, 1'b0, 64'h0000_0000_7F80_0001, 64'h0000_0000_7F80_0001, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        in_dbl = 1'b0;
  logic        in_legacy = 1'b0;
  logic        out_valid;
  logic [63:0] out_res;
  logic        out_invalid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  snan_quieter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dbl(in_dbl), .in_legacy(in_legacy),
    .out_valid(out_valid), .out_res(out_res), .out_invalid(out_invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'b0, out_valid}, 64'd0);
    check("R1 reset flag", {63'b0, out_invalid}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_op     = VEC[i].op;
      in_dbl    = VEC[i].dbl;
      in_legacy = VEC[i].leg;
      @(negedge clk);
      check($sformatf("%s vector %0d result", VEC[i].tag, i), out_res, VEC[i].res);
      check($sformatf("%s vector %0d flag", VEC[i].tag, i), {63'b0, out_invalid}, {63'b0, VEC[i].flag});
      check($sformatf("R1 vector %0d valid", i), {63'b0, out_valid}, 64'd1);
    end

    // R8: sNaN on the input with strobe low raises nothing
    @(negedge clk);
    in_valid  = 1'b0;
    in_op     = 64'h7FF0_0000_0000_0001;
    in_dbl    = 1'b1;
    in_legacy = 1'b0;
    @(negedge clk);
    check("R8 idle flag", {63'b0, out_invalid}, 64'd0);
    check("R1 idle valid", {63'b0, out_valid}, 64'd0);

    // R1: reset during traffic clears valid and flag
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 flagged before reset", {63'b0, out_invalid}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run valid", {63'b0, out_valid}, 64'd0);
    check("R1 reset mid-run flag", {63'b0, out_invalid}, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;

    // R5: positive binary64 legacy corner, back to back with binary32 corner
    @(negedge clk);
    in_valid  = 1'b1;
    in_legacy = 1'b1;
    in_dbl    = 1'b1;
    in_op     = 64'h7FF8_0000_0000_0000;
    @(negedge clk);
    check("R5 dbl positive corner", out_res, 64'h7FF4_0000_0000_0000);
    in_dbl = 1'b0;
    in_op  = 64'hAAAA_AAAA_FFC0_0000;
    @(negedge clk);
    check("R5 sgl negative corner", out_res, 64'h0000_0000_FFA0_0000);
    check("R5 sgl corner flag", {63'b0, out_invalid}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule